// File: doc/BRIEF.md
# Trigger Latency Pipeline with Multi-Event Readout Buffer

This block sits behind a trigger processor and holds the processor's data stream back by a programmable number of clocks. The delay makes each data word reach the capture point in the same clock as the trigger decision that refers to it. The delay is a circular RAM. A free-running write pointer addresses it, and the read tap trails the write pointer by the programmed latency. The latency register is loaded through a plain configuration write strobe.

Three fast-control strobes work on the event buffer, one for each operation. An accept strobe captures a fixed-length event of delayed words. A read strobe drains one stored event through the readout stream. A clear strobe throws away everything that is stored or pending. The buffer holds several events. An accept that arrives while a capture is running is queued. An accept that would exceed capacity is dropped and raises a sticky overflow flag. A read with no event to give raises a sticky error flag.

The input stream has no ready signal, because the delay line runs every clock and takes every word. The readout stream is valid/ready. `out_valid` stays asserted and `out_data`/`out_last` hold steady while `out_ready` is low. A word is consumed only on a clock where valid and ready are both high.

Top module: `trig_latency_evbuf`

## Requirements
- R1: `lat_data`/`lat_valid` equal `in_data`/`in_valid` as sampled exactly L clocks earlier, where L is the programmed latency in the range 1 to 255.
- R2: After reset the latency is 4. A configuration write of 0 is ignored and leaves the previous latency in force.
- R3: An accept taken while no capture is running stores 8 consecutive delayed words. The first is the delayed word present in the accept clock. A delayed slot whose `lat_valid` is low is stored as 0.
- R4: A read strobe that finds a stored event not yet claimed by an earlier read makes `out_valid` rise on the next clock. The 8 words then follow in capture order, with `out_last` high on the eighth only.
- R5: Events leave the buffer in the order they were captured.
- R6: An accept that arrives during a capture is queued. Its capture begins on the clock after the running capture writes its eighth word.
- R7: An accept that arrives while stored, capturing and queued events already total 4 is dropped and sets `overflow`. The flag stays set until a clear. `ev_count` never exceeds 4.
- R8: A read strobe with no unclaimed stored event produces no output word and sets `read_error`. The flag stays set until a clear.
- R9: A clear strobe empties the buffer, the queue and any capture or drain in progress, and clears both flags. It takes priority over an accept or read in the same clock. The latency path is not affected.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R11: During and right after reset, `lat_valid`, `out_valid`, `ev_count`, `overflow` and `read_error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 8 | Input data word |
| cfg_we | input | 1 | Latency write strobe |
| cfg_latency | input | 8 | Latency value to load (0 ignored) |
| l1_accept | input | 1 | Trigger accept strobe |
| read_event | input | 1 | Read one event strobe |
| clear_readout | input | 1 | Discard all events strobe |
| lat_valid | output | 1 | Delayed word qualifier |
| lat_data | output | 8 | Delayed data word |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Readout sink ready |
| out_data | output | 8 | Readout data word |
| out_last | output | 1 | Last word of the event |
| ev_count | output | 3 | Events stored and not fully read out |
| overflow | output | 1 | Sticky dropped-accept flag |
| read_error | output | 1 | Sticky read-on-empty flag |

## Verification
The bench sweeps every latency from 1 to 255 against the free-running input count. A read tap off by one clock, or with the subtraction reversed, shows up as a constant offset in `lat_data`. An accept placed so that an invalid input slot falls inside the event shows whether invalid words are zeroed, and whether the first word comes from the accept clock or one clock late. A second accept during a capture, a fifth accept into a full buffer and a read on an empty buffer target the queue, capacity and error logic. A design that lost queued accepts, or over-counted capacity, returns the wrong number of events or words shifted by 8. A clear issued together with an accept, and a readout stalled in the middle of an event, expose wrong priority and words that are skipped or repeated under back-pressure.

// File: rtl/lev_pkg.sv
package lev_pkg;
  // Default configuration shared by the top level and the bench.
  localparam int LEV_DW        = 8;
  localparam int LEV_LAT_W     = 8;
  localparam int LEV_EVENTS    = 4;
  localparam int LEV_WORDS     = 8;
  localparam int LEV_LAT_RESET = 4;
endpackage

// File: rtl/lev_delay_line.sv
module lev_delay_line #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] lat,
  output logic          dly_valid,
  output logic [DW-1:0] dly_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    wp_q;
  logic [AW-1:0]    rp;

  // Read tap trails the write pointer by the latency.
  assign rp = wp_q - lat;

  always_ff @(posedge clk) begin
    mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      vld_q <= '0;
    end else begin
      wp_q        <= wp_q + 1'b1;
      vld_q[wp_q] <= in_valid;
    end
  end

  assign dly_valid = vld_q[rp];
  assign dly_data  = mem[rp];
endmodule

// File: rtl/lev_capture.sv
module lev_capture #(
  parameter int EVENTS = 4,
  parameter int WORDS  = 8,
  localparam int CNT_W  = $clog2(EVENTS + 1),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept,
  input  logic [CNT_W-1:0]  ev_cnt,
  output logic              cap_we,
  output logic [WIDX_W-1:0] cap_idx,
  output logic              cap_last,
  output logic              ovf
);
  logic              busy_q;
  logic [WIDX_W-1:0] wcnt_q;
  logic [CNT_W-1:0]  pend_q;
  logic              ovf_q;
  logic              room;
  logic              acc_take;
  logic              acc_drop;
  logic              launch;

  // Capacity counts stored, in-flight and queued events.
  assign room     = (int'(ev_cnt) + int'(busy_q) + int'(pend_q)) < EVENTS;
  assign acc_take = accept && !clr && room;
  assign acc_drop = accept && !clr && !room;
  assign launch   = !busy_q && ((pend_q != '0) || acc_take);
  assign cap_we   = !clr && (busy_q || launch);
  assign cap_idx  = busy_q ? wcnt_q : '0;
  assign cap_last = cap_we && (cap_idx == WIDX_W'(WORDS - 1));
  assign ovf      = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clr) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      busy_q <= cap_we && !cap_last;
      if (cap_we) begin
        wcnt_q <= cap_last ? '0 : cap_idx + 1'b1;
      end
      pend_q <= pend_q + CNT_W'(acc_take) - CNT_W'(launch);
      if (acc_drop) begin
        ovf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lev_event_store.sv
module lev_event_store #(
  parameter int DW     = 8,
  parameter int EVENTS = 4,
  parameter int WORDS  = 8,
  localparam int CNT_W  = $clog2(EVENTS + 1),
  localparam int WIDX_W = $clog2(WORDS),
  localparam int SLOT_W = $clog2(EVENTS),
  localparam int ADDR_W = SLOT_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_we,
  input  logic [WIDX_W-1:0] cap_idx,
  input  logic              cap_last,
  input  logic [DW-1:0]     cap_data,
  input  logic              rd_event,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic [CNT_W-1:0]  ev_cnt,
  output logic              rd_err
);
  logic [DW-1:0]     mem [EVENTS*WORDS];
  logic [SLOT_W-1:0] wslot_q;
  logic [SLOT_W-1:0] rslot_q;
  logic [WIDX_W-1:0] rword_q;
  logic [CNT_W-1:0]  ev_cnt_q;
  logic [CNT_W-1:0]  claim_q;
  logic              err_q;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic              pop;
  logic              done;
  logic              rd_take;
  logic              rd_miss;

  assign waddr = {wslot_q, cap_idx};
  assign raddr = {rslot_q, rword_q};

  always_ff @(posedge clk) begin
    if (cap_we) begin
      mem[waddr] <= cap_data;
    end
  end

  assign out_valid = (claim_q != '0);
  assign out_data  = mem[raddr];
  assign out_last  = out_valid && (rword_q == WIDX_W'(WORDS - 1));
  assign pop       = out_valid && out_ready;
  assign done      = pop && out_last;
  assign rd_take   = rd_event && !clr && (ev_cnt_q != claim_q);
  assign rd_miss   = rd_event && !clr && (ev_cnt_q == claim_q);
  assign ev_cnt    = ev_cnt_q;
  assign rd_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q  <= '0;
      rslot_q  <= '0;
      rword_q  <= '0;
      ev_cnt_q <= '0;
      claim_q  <= '0;
      err_q    <= 1'b0;
    end else if (clr) begin
      wslot_q  <= '0;
      rslot_q  <= '0;
      rword_q  <= '0;
      ev_cnt_q <= '0;
      claim_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      if (cap_last) begin
        wslot_q <= wslot_q + 1'b1;
      end
      if (pop) begin
        rword_q <= out_last ? '0 : rword_q + 1'b1;
      end
      if (done) begin
        rslot_q <= rslot_q + 1'b1;
      end
      ev_cnt_q <= ev_cnt_q + CNT_W'(cap_last) - CNT_W'(done);
      claim_q  <= claim_q + CNT_W'(rd_take) - CNT_W'(done);
      if (rd_miss) begin
        err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_latency_evbuf.sv
module trig_latency_evbuf #(
  parameter int DW        = lev_pkg::LEV_DW,
  parameter int LAT_W     = lev_pkg::LEV_LAT_W,
  parameter int EVENTS    = lev_pkg::LEV_EVENTS,
  parameter int WORDS     = lev_pkg::LEV_WORDS,
  parameter int LAT_RESET = lev_pkg::LEV_LAT_RESET,
  localparam int CNT_W  = $clog2(EVENTS + 1),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             cfg_we,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             l1_accept,
  input  logic             read_event,
  input  logic             clear_readout,
  output logic             lat_valid,
  output logic [DW-1:0]    lat_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] ev_count,
  output logic             overflow,
  output logic             read_error
);
  logic [LAT_W-1:0]  lat_q;
  logic              cap_we;
  logic [WIDX_W-1:0] cap_idx;
  logic              cap_last;
  logic [DW-1:0]     cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= LAT_W'(LAT_RESET);
    end else if (cfg_we && (cfg_latency != '0)) begin
      lat_q <= cfg_latency;
    end
  end

  lev_delay_line #(.DW(DW), .AW(LAT_W)) i_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .lat       (lat_q),
    .dly_valid (lat_valid),
    .dly_data  (lat_data)
  );

  assign cap_data = lat_valid ? lat_data : '0;

  lev_capture #(.EVENTS(EVENTS), .WORDS(WORDS)) i_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clear_readout),
    .accept   (l1_accept),
    .ev_cnt   (ev_count),
    .cap_we   (cap_we),
    .cap_idx  (cap_idx),
    .cap_last (cap_last),
    .ovf      (overflow)
  );

  lev_event_store #(.DW(DW), .EVENTS(EVENTS), .WORDS(WORDS)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clear_readout),
    .cap_we    (cap_we),
    .cap_idx   (cap_idx),
    .cap_last  (cap_last),
    .cap_data  (cap_data),
    .rd_event  (read_event),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .ev_cnt    (ev_count),
    .rd_err    (read_error)
  );
endmodule

// File: rtl/lev_checker.sv
module lev_checker #(
  parameter int DW     = 8,
  parameter int LAT_W  = 8,
  parameter int EVENTS = 4,
  localparam int CNT_W = $clog2(EVENTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             cfg_we,
  input logic [LAT_W-1:0] cfg_latency,
  input logic [LAT_W-1:0] lat_q,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             out_last,
  input logic [CNT_W-1:0] ev_count,
  input logic             overflow,
  input logic             read_error
);
  a_r2_zero_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_latency == '0) |=> $stable(lat_q));

  a_r2_latency_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q != '0);

  a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ev_count) <= EVENTS);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  a_r8_no_data_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ev_count != '0));

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (read_error && !clr) |=> read_error);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ev_count == '0 && !out_valid && !overflow && !read_error));

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind trig_latency_evbuf lev_checker #(
  .DW(DW), .LAT_W(LAT_W), .EVENTS(EVENTS)
) i_lev_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clear_readout),
  .cfg_we      (cfg_we),
  .cfg_latency (cfg_latency),
  .lat_q       (lat_q),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_last    (out_last),
  .ev_count    (ev_count),
  .overflow    (overflow),
  .read_error  (read_error)
);

// File: tb/test_trig_latency_evbuf.sv
module test_trig_latency_evbuf;
  localparam int CLK_PERIOD = 10;
  localparam int L = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_latency = 8'd0;
  logic       l1_accept = 1'b0;
  logic       read_event = 1'b0;
  logic       clear_readout = 1'b0;
  logic       out_ready = 1'b1;
  logic       lat_valid;
  logic [7:0] lat_data;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic [2:0] ev_count;
  logic       overflow;
  logic       read_error;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_latency_evbuf i_trig_latency_evbuf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_latency(cfg_latency), .l1_accept(l1_accept),
    .read_event(read_event), .clear_readout(clear_readout),
    .lat_valid(lat_valid), .lat_data(lat_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .ev_count(ev_count), .overflow(overflow), .read_error(read_error)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs change only just after the falling edge.
  task automatic tick();
    @(negedge clk);
    in_data = in_data + 8'd1;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_lat(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_latency = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic accept(output logic [7:0] a);
    l1_accept = 1'b1;
    a = in_data;
    tick();
    l1_accept = 1'b0;
  endtask

  // Read one event and compare with base+k; slot zval reads 0 when use_z.
  task automatic read_check(input logic [7:0] base, input bit use_z,
                            input logic [7:0] zval, input string tag);
    logic [7:0] e;
    read_event = 1'b1;
    tick();
    read_event = 1'b0;
    for (int k = 0; k < 8; k++) begin
      e = base + 8'(k);
      if (use_z && e == zval) e = 8'd0;
      chk(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
      chk(out_data == e, {tag, " data"}, int'(out_data), int'(e));
      chk(out_last == (k == 7), {tag, " last"}, int'(out_last), int'(k == 7));
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] a, a2, b;
    logic [7:0] bases [4];

    ticks(3);
    // R11: reset state
    chk(lat_valid == 1'b0, "R11 lat_valid", int'(lat_valid), 0);
    chk(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
    chk(ev_count == 3'd0, "R11 ev_count", int'(ev_count), 0);
    chk(overflow == 1'b0 && read_error == 1'b0, "R11 flags",
        int'({overflow, read_error}), 0);
    rst_n = 1'b1;
    tick();
    chk(out_valid == 1'b0 && ev_count == 3'd0, "R11 after release",
        int'(ev_count), 0);
    in_valid = 1'b1;
    ticks(260);

    // R2: default latency is 4
    chk(lat_valid && lat_data == in_data - 8'd4, "R2 default latency",
        int'(lat_data), int'(in_data - 8'd4));

    // R1: exhaustive latency sweep
    for (int v = 1; v < 256; v++) begin
      set_lat(8'(v));
      chk(lat_valid && lat_data == in_data - 8'(v), "R1 latency sweep",
          int'(lat_data), int'(in_data - 8'(v)));
    end

    // R2: writing 0 keeps the latency
    set_lat(8'd9);
    set_lat(8'd0);
    ticks(2);
    chk(lat_data == in_data - 8'd9, "R2 zero write ignored",
        int'(lat_data), int'(in_data - 8'd9));

    set_lat(8'(L));
    ticks(3);

    // R3/R4: single event, invalid slot lands on word 2
    b = in_data;
    in_valid = 1'b0;
    tick();
    in_valid = 1'b1;
    ticks(L - 3);
    chk(in_data == b + 8'(L) - 8'd2, "R3 setup", int'(in_data), int'(b + 8'(L) - 8'd2));
    accept(a);
    ticks(9);
    chk(ev_count == 3'd1, "R3 ev_count", int'(ev_count), 1);
    read_check(a - 8'(L), 1'b1, b, "R3 R4 event");
    chk(ev_count == 3'd0 && !out_valid, "R4 drained", int'(ev_count), 0);

    // R6: accept during capture is queued
    accept(a);
    ticks(2);
    accept(a2);
    ticks(20);
    chk(ev_count == 3'd2, "R6 two events", int'(ev_count), 2);
    read_check(a - 8'(L), 1'b0, 8'd0, "R6 first");
    read_check(a + 8'd8 - 8'(L), 1'b0, 8'd0, "R6 queued");

    // R7: fill to four, fifth dropped
    for (int i = 0; i < 4; i++) begin
      accept(a);
      bases[i] = a - 8'(L);
      ticks(10);
    end
    chk(ev_count == 3'd4 && !overflow, "R7 full", int'(ev_count), 4);
    accept(a);
    chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
    ticks(10);
    chk(ev_count == 3'd4, "R7 dropped", int'(ev_count), 4);

    // R5: order of readout
    for (int i = 0; i < 4; i++) read_check(bases[i], 1'b0, 8'd0, "R5 order");
    chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);

    // R8: read on empty
    read_event = 1'b1;
    tick();
    read_event = 1'b0;
    chk(read_error == 1'b1 && !out_valid, "R8 error", int'(read_error), 1);
    tick();
    chk(!out_valid && read_error, "R8 no data", int'(out_valid), 0);

    // R10: back-pressure in mid-event
    accept(a);
    ticks(10);
    read_event = 1'b1;
    tick();
    read_event = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k == 3) begin
        out_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
          tick();
          chk(out_valid && out_data == a - 8'(L) + 8'd3, "R10 stall hold",
              int'(out_data), int'(a - 8'(L) + 8'd3));
        end
        out_ready = 1'b1;
      end
      chk(out_valid && out_data == a - 8'(L) + 8'(k), "R10 data",
          int'(out_data), int'(a - 8'(L) + 8'(k)));
      tick();
    end
    chk(!out_valid && ev_count == 3'd0, "R10 done", int'(ev_count), 0);

    // R9: clear with simultaneous accept
    accept(a);
    ticks(10);
    accept(a);
    ticks(10);
    chk(ev_count == 3'd2, "R9 setup", int'(ev_count), 2);
    clear_readout = 1'b1;
    l1_accept = 1'b1;
    tick();
    clear_readout = 1'b0;
    l1_accept = 1'b0;
    chk(ev_count == 3'd0 && !out_valid, "R9 emptied", int'(ev_count), 0);
    chk(!overflow && !read_error, "R9 flags cleared",
        int'({overflow, read_error}), 0);
    ticks(10);
    chk(ev_count == 3'd0, "R9 accept ignored", int'(ev_count), 0);
    chk(lat_data == in_data - 8'(L), "R9 latency kept",
        int'(lat_data), int'(in_data - 8'(L)));
    accept(a);
    ticks(10);
    read_check(a - 8'(L), 1'b0, 8'd0, "R9 after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule